// File: doc/BRIEF.md
# Sticky-Enable Watchdog Timer

This block is a watchdog timer peripheral with a small 16-bit register interface. Software picks a timeout, in half-second steps, and sets an enable bit. From then on, a slow tick input, which pulses twice per second, counts the timer down. Software must keep restarting the count before it runs out. If the count expires, the block raises a single-cycle system reset request, reloads the count and keeps running.

A restart is a guarded two-write sequence. The service register must receive a first key and then a second, different key, in that order. Any other write pattern discards the partial sequence. Once the enable bit is set, nothing but the block's synchronous reset can clear it. Software can still change the timeout field with a read-modify-write of the control register, and the new value applies from the next reload.

The bus is a plain valid/write/address/data request. Read data comes back one clock after the read request, flagged by a response valid.

Top module: `sticky_wdt`

## Requirements
- R1: After synchronous reset the control word reads 0x0000, the count reads 1 and the reset request output is low.
- R2: The control register is at word address 0, with the timeout field in bits [7:0] and the enable bit in bit 15. The service register is at address 1 and reads as 0. The current count is readable at address 2, and address 3 reads as 0. Read data and rsp_valid appear in the clock after the read request.
- R3: While the enable bit is 0, the count equals the timeout field plus one, tick pulses are ignored, and no reset request is issued.
- R4: Once the enable bit is 1, a control write with bit 15 at 0 leaves it at 1 until the synchronous reset.
- R5: The control write that first sets the enable bit loads the count with its own timeout field plus one.
- R6: With enable set and no restart, the reset request rises in the clock after the (timeout+1)-th tick since the last load, stays high for exactly one clock, and the count reloads to timeout+1 and continues.
- R7: A write of 0x5555 to the service register followed by a write of 0xAAAA to it reloads the count with timeout+1. A repeated 0x5555 keeps the sequence pending.
- R8: A 0xAAAA with no pending 0x5555, or any other value written to the service register, discards the pending sequence and leaves the count unchanged.
- R9: Rewriting the timeout field while enabled does not change the running count. The new value is used at the next reload.
- R10: While enabled, each tick pulse that causes no expiry lowers the count by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_2hz | input | 1 | One-clock pulse twice per second |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one clock after a read |
| rsp_rdata | output | 16 | Read data |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The enable bit is sticky, so a test cannot switch it off after one scenario. Each timeout value needs a fresh reset, then arming, then a full walk of ticks up to expiry. The bench does this for all 256 timeout values, and predicts the exact tick at which the reset request must appear and the count it must reload to. Key-sequence corner cases need a counter that is partly drained, so that a wrong restart shows up as a changed count. The bench drains a few ticks before each key pattern, then reads the count back through the bus.

// File: rtl/sticky_wdt_pkg.sv
package sticky_wdt_pkg;
  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_HALF  = 1'b1
  } key_state_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_SVC  = 1;
  localparam int unsigned REG_CNT  = 2;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [TMO_W-1:0] wr_tmo,
  input  logic             wr_en_bit,
  output logic             en_q,
  output logic [TMO_W-1:0] tmo_q,
  output logic             arm_pulse
);
  // The first enabling write arms the counter; later writes only move the field.
  assign arm_pulse = wr_stb && wr_en_bit && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      tmo_q <= '0;
    end else if (wr_stb) begin
      tmo_q <= wr_tmo;
      if (wr_en_bit) en_q <= 1'b1;
    end
  end

  assert_enable_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    en_q |=> en_q);
  assert_field_written_R9: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> tmo_q == $past(wr_tmo));
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import sticky_wdt_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 'h5555,
  parameter logic [DATA_W-1:0] KEY_SECOND = 'hAAAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] svc_data,
  output logic              restart
);
  key_state_e st_q;

  assign restart = svc_wr && (st_q == KS_HALF) && (svc_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KS_IDLE;
    end else if (svc_wr) begin
      // any write other than the first key resolves or abandons the sequence
      st_q <= (svc_data == KEY_FIRST) ? KS_HALF : KS_IDLE;
    end
  end

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> st_q == KS_IDLE);
  assert_first_key_pends_R7: assert property (@(posedge clk) disable iff (rst)
    (svc_wr && svc_data == KEY_FIRST) |=> st_q == KS_HALF);
  assert_bad_word_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (svc_wr && svc_data != KEY_FIRST) |=> st_q == KS_IDLE);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int TMO_W = 8,
  localparam int CNT_W = TMO_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [TMO_W-1:0] tmo,
  input  logic             arm,
  input  logic [TMO_W-1:0] arm_tmo,
  input  logic             restart,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire_q
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] arm_reload;

  assign reload     = {1'b0, tmo} + CNT_W'(1);
  assign arm_reload = {1'b0, arm_tmo} + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= CNT_W'(1);
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (arm) begin
        cnt_q <= arm_reload;
      end else if (!en || restart) begin
        cnt_q <= reload;
      end else if (tick) begin
        if (cnt_q == CNT_W'(1)) begin
          expire_q <= 1'b1;
          cnt_q    <= reload;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assert_no_bite_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !expire_q);
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    expire_q |=> !expire_q);
  assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0);
  assert_step_down_R10: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !arm && !restart && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/sticky_wdt.sv
module sticky_wdt
  import sticky_wdt_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                ADDR_W     = 2,
  parameter int                TMO_W      = 8,
  parameter int                EN_BIT     = 15,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 'h5555,
  parameter logic [DATA_W-1:0] KEY_SECOND = 'hAAAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_2hz,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rst_req
);
  localparam int CNT_W = TMO_W + 1;

  logic             wr_ctrl, wr_svc, rd_req;
  logic             en_q, arm_pulse, restart, expire_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] ctrl_word, rd_mux;

  assign wr_ctrl = req_valid && req_write && (req_addr == ADDR_W'(REG_CTRL));
  assign wr_svc  = req_valid && req_write && (req_addr == ADDR_W'(REG_SVC));
  assign rd_req  = req_valid && !req_write;

  wdt_ctrl_reg #(.TMO_W(TMO_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_ctrl),
    .wr_tmo    (req_wdata[TMO_W-1:0]),
    .wr_en_bit (req_wdata[EN_BIT]),
    .en_q      (en_q),
    .tmo_q     (tmo_q),
    .arm_pulse (arm_pulse)
  );

  wdt_key_seq #(
    .DATA_W     (DATA_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_keys (
    .clk      (clk),
    .rst      (rst),
    .svc_wr   (wr_svc),
    .svc_data (req_wdata),
    .restart  (restart)
  );

  wdt_countdown #(.TMO_W(TMO_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .tmo      (tmo_q),
    .arm      (arm_pulse),
    .arm_tmo  (req_wdata[TMO_W-1:0]),
    .restart  (restart),
    .tick     (tick_2hz),
    .cnt_q    (cnt_q),
    .expire_q (expire_q)
  );

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[TMO_W-1:0]     = tmo_q;
    ctrl_word[EN_BIT]        = en_q;
    unique case (req_addr)
      ADDR_W'(REG_CTRL): rd_mux = ctrl_word;
      ADDR_W'(REG_CNT):  rd_mux = DATA_W'(cnt_q);
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_mux;
    end
  end

  assign rst_req = expire_q;

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);
endmodule

// File: tb/test_sticky_wdt.sv
module test_sticky_wdt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_2hz = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rst_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sticky_wdt i_sticky_wdt (
    .clk(clk), .rst(rst), .tick_2hz(tick_2hz),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rst_req(rst_req)
  );

  localparam logic [1:0] A_CTRL = 2'd0, A_SVC = 2'd1, A_CNT = 2'd2, A_SPARE = 2'd3;
  localparam logic [15:0] EN = 16'h8000, K1 = 16'h5555, K2 = 16'hAAAA;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d, output int v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = int'(rsp_rdata); v = int'(rsp_valid);
  endtask

  task automatic tick(output int fired);
    @(negedge clk); tick_2hz = 1'b1;
    @(posedge clk);
    @(negedge clk); tick_2hz = 1'b0;
    fired = int'(rst_req);
  endtask

  task automatic rd_cnt(input string req, input int exp);
    int d, v;
    rd(A_CNT, d, v);
    check(req, d, exp);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    int d, v, f, early;
    do_reset();
    // R1 reset state
    check("R1 rst_req", int'(rst_req), 0);
    rd(A_CTRL, d, v);
    check("R1 ctrl", d, 0);
    check("R2 rsp_valid", v, 1);
    rd_cnt("R1 count", 1);
    @(negedge clk);
    check("R2 rsp_valid idle", int'(rsp_valid), 0);
    rd(A_SVC, d, v);  check("R2 svc reads 0", d, 0);
    rd(A_SPARE, d, v); check("R2 spare reads 0", d, 0);

    // R3 disabled: count follows field, ticks ignored
    wr(A_CTRL, 16'h0005);
    rd_cnt("R3 follows field", 6);
    early = 0;
    for (int i = 0; i < 10; i++) begin tick(f); early += f; end
    check("R3 no request", early, 0);
    rd_cnt("R3 ticks ignored", 6);
    wr(A_CTRL, 16'h0007);
    rd_cnt("R3 follows new field", 8);
    rd(A_CTRL, d, v); check("R2 ctrl readback", d, 16'h0007);

    // R5 R6 exhaustive over timeout values
    for (int t = 0; t < 256; t++) begin
      do_reset();
      wr(A_CTRL, EN | 16'(t));
      rd_cnt("R5 arm load", t + 1);
      early = 0;
      for (int i = 0; i < t; i++) begin tick(f); early += f; end
      check("R6 no early request", early, 0);
      tick(f);
      check("R6 request on expiry", f, 1);
      @(negedge clk);
      check("R6 one clock pulse", int'(rst_req), 0);
      rd_cnt("R6 reload after expiry", t + 1);
    end

    // R6 keeps running; R10 single steps
    do_reset();
    wr(A_CTRL, EN | 16'd5);
    tick(f); tick(f);
    rd_cnt("R10 two ticks", 4);
    for (int i = 0; i < 4; i++) tick(f);
    check("R6 first expiry", f, 1);
    early = 0;
    for (int i = 0; i < 5; i++) begin tick(f); early += f; end
    check("R6 no early second", early, 0);
    tick(f);
    check("R6 second expiry", f, 1);

    // R7 R8 key sequences
    do_reset();
    wr(A_CTRL, EN | 16'd9);
    tick(f); tick(f); tick(f);
    rd_cnt("R10 three ticks", 7);
    wr(A_SVC, K1); wr(A_SVC, K2);
    rd_cnt("R7 restart", 10);
    tick(f);
    wr(A_SVC, K2);
    rd_cnt("R8 lone second key", 9);
    wr(A_SVC, K1); wr(A_SVC, 16'h1234); wr(A_SVC, K2);
    rd_cnt("R8 broken sequence", 9);
    wr(A_SVC, K2); wr(A_SVC, K1);
    rd_cnt("R8 reversed order", 9);
    wr(A_SVC, K2);
    rd_cnt("R7 completes after reversed", 10);
    tick(f);
    wr(A_SVC, K1); wr(A_SVC, K1); wr(A_SVC, K2);
    rd_cnt("R7 repeated first key", 10);

    // R4 sticky enable, R9 deferred timeout
    tick(f);
    wr(A_CTRL, 16'h0003);
    rd(A_CTRL, d, v); check("R4 enable stays", d, 16'h8003);
    rd_cnt("R9 count untouched", 9);
    wr(A_SVC, K1); wr(A_SVC, K2);
    rd_cnt("R9 new value at reload", 4);
    for (int i = 0; i < 4; i++) tick(f);
    check("R4 still bites", f, 1);
    wr(A_CTRL, 16'h0000);
    rd(A_CTRL, d, v); check("R4 zero write ignored", d, 16'h8000);

    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    report();
  end
endmodule